// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a switched-capacitor successive-approximation converter. When a start pulse arrives while the block is idle, it stores the chosen resolution (8, 10 or 12 bits) and the acquisition length. It then runs a fixed sequence. First it discharges the array for one cycle. Next it connects the input for the programmed number of acquisition cycles. Then it holds for one cycle with every capacitor grounded. Last, it runs one bit trial per clock, starting at the MSB. Each trial is decided by a single comparator input.

The switch vector carries one bit per capacitor, with bit 11 driving the largest capacitor. A switch bit of 1 ties that capacitor to the reference and 0 ties it to ground. The phase output tells the analog side whether the array is being discharged, is sampling the input, or is holding. When the last decision is taken, the block registers the right-justified result and pulses a done strobe for one cycle.

Top module: `sar_conv_seq`

## Requirements
- R1: When reset is asserted, the block goes idle (phase code 0). All switches are grounded, busy and done are low, and the result is cleared. This holds even if a conversion is in progress.
- R2: If start is high at a clock edge while the block is idle, the conversion is accepted. From the next cycle busy is high and the phase is discharge (code 1).
- R3: Discharge lasts exactly one cycle and is followed by acquisition (code 2). The switch vector is all zero in every phase except trial (code 4).
- R4: Acquisition lasts A cycles, where A is the acquisition length latched at start. A length of 0 is treated as 1.
- R5: Hold (code 3) lasts exactly one cycle with all switches grounded. The first trial cycle shows only switch bit 11 set (0x800).
- R6: The comparator is sampled at the end of each trial cycle. If it reads 1, the trial switch stays on the reference; if it reads 0, the switch returns to ground. In either case the next lower switch is raised for the following trial.
- R7: Resolution select 0 gives 8 bits, 1 gives 10 bits, and 2 or 3 gives 12 bits. Trials use only the top N switches, and the unused low switches stay grounded.
- R8: The result holds the N decided bits right-justified, with the bits above N zero. With a comparator that reads 1 when the input code is at or above the switch vector, the result equals the 12-bit input code shifted right by 12−N.
- R9: Busy stays high for exactly A+N+2 cycles: one discharge cycle plus A acquisition cycles, plus N+1 cycles for hold and trials.
- R10: Done is high for exactly one cycle, which is the first cycle with busy low. The result changes only when done rises.
- R11: A start pulse that arrives while busy is ignored. It does not restart the conversion or change its length.
- R12: Changing the resolution select or the acquisition length during a conversion has no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Conversion request, accepted only when idle |
| res_sel_i | input | 2 | Resolution select: 0 = 8 bits, 1 = 10 bits, 2 or 3 = 12 bits |
| acq_len_i | input | ACQ_W | Acquisition length in clock cycles (0 is treated as 1) |
| cmp_i | input | 1 | Comparator decision for the current trial |
| sw_o | output | 12 | Capacitor switch controls, 1 = reference, bit 11 = largest capacitor |
| phase_o | output | 3 | Phase: 0 idle, 1 discharge, 2 acquire, 3 hold, 4 trial |
| busy_o | output | 1 | High from the cycle after start is accepted until done |
| result_o | output | 12 | Right-justified conversion result |
| done_o | output | 1 | One-cycle strobe when the result is updated |

## Verification
An accepted start produces the discharge phase in the very next cycle. Busy then stays high for A+N+2 cycles. Done and the new result appear in the first cycle in which busy is low. During the trials, each comparator decision shows up on the switch vector one cycle after it is sampled. The bench drives its inputs and samples all outputs on falling edges. It counts the busy cycles and compares that count against A+N+2. It checks done and the result in the cycle where busy drops, and checks the trial-by-trial switch values on successive falling edges from the first trial cycle onward.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int unsigned SAR_MAX_BITS = 12;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DISCH = 3'd1,
    PH_ACQ   = 3'd2,
    PH_HOLD  = 3'd3,
    PH_TRIAL = 3'd4
  } sar_phase_e;

  // Resolution select to bit count: 0 -> 8, 1 -> 10, otherwise 12.
  function automatic logic [3:0] res_width(input logic [1:0] sel);
    logic [3:0] w;
    case (sel)
      2'd0:    w = 4'd8;
      2'd1:    w = 4'd10;
      default: w = 4'd12;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_pkg::*;
#(
  parameter int unsigned ACQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       res_sel_i,
  input  logic [ACQ_W-1:0] acq_len_i,
  output sar_phase_e       phase_o,
  output logic [3:0]       nbits_o,
  output logic             arm_o,
  output logic             step_o,
  output logic             last_o
);

  localparam int unsigned CNT_W = (ACQ_W > 4) ? ACQ_W : 4;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [ACQ_W-1:0] ACQ_MIN = ACQ_W'(1);

  sar_phase_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [ACQ_W-1:0] acq_q, acq_n;
  logic [3:0]       nbits_q;
  logic             lat_en;

  assign lat_en = (state_q == PH_IDLE) && start_i;
  assign acq_n  = (acq_len_i == '0) ? ACQ_MIN : acq_len_i;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    case (state_q)
      PH_IDLE: begin
        if (start_i) state_n = PH_DISCH;
      end
      PH_DISCH: begin
        state_n = PH_ACQ;
        cnt_n   = CNT_W'(acq_q) - CNT_ONE;
      end
      PH_ACQ: begin
        if (cnt_q == '0) state_n = PH_HOLD;
        else             cnt_n   = cnt_q - CNT_ONE;
      end
      PH_HOLD: begin
        state_n = PH_TRIAL;
        cnt_n   = CNT_W'(nbits_q) - CNT_ONE;
      end
      PH_TRIAL: begin
        if (cnt_q == '0) state_n = PH_IDLE;
        else             cnt_n   = cnt_q - CNT_ONE;
      end
      default: state_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_q   <= ACQ_MIN;
      nbits_q <= 4'd12;
    end else if (lat_en) begin
      acq_q   <= acq_n;
      nbits_q <= res_width(res_sel_i);
    end
  end

  assign phase_o = state_q;
  assign nbits_o = nbits_q;
  assign arm_o   = (state_q == PH_HOLD);
  assign step_o  = (state_q == PH_TRIAL);
  assign last_o  = (cnt_q == '0);

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import sar_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arm_i,
  input  logic                    step_i,
  input  logic                    last_i,
  input  logic                    cmp_i,
  input  logic [3:0]              nbits_i,
  output logic [SAR_MAX_BITS-1:0] sw_o,
  output logic [SAR_MAX_BITS-1:0] result_o,
  output logic                    done_o
);

  localparam int unsigned W = SAR_MAX_BITS;
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sw_q, sw_n;
  logic [W-1:0] bit_q, bit_n;
  logic [W-1:0] res_q, res_n;
  logic [W-1:0] keep;
  logic         res_en;
  logic         done_q;

  // Decision on the bit under trial: keep it on the reference or drop it.
  assign keep = cmp_i ? sw_q : (sw_q & ~bit_q);

  always_comb begin
    sw_n   = sw_q;
    bit_n  = bit_q;
    res_en = 1'b0;
    if (arm_i) begin
      sw_n  = TOP_BIT;
      bit_n = TOP_BIT;
    end else if (step_i) begin
      if (last_i) begin
        sw_n   = '0;
        bit_n  = '0;
        res_en = 1'b1;
      end else begin
        bit_n = bit_q >> 1;
        sw_n  = keep | (bit_q >> 1);
      end
    end
  end

  assign res_n = keep >> (W - 32'(nbits_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sw_q   <= sw_n;
      bit_q  <= bit_n;
      done_q <= res_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_n;
  end

  assign sw_o     = sw_q;
  assign result_o = res_q;
  assign done_o   = done_q;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int unsigned ACQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       res_sel_i,
  input  logic [ACQ_W-1:0] acq_len_i,
  input  logic             cmp_i,
  output logic [11:0]      sw_o,
  output logic [2:0]       phase_o,
  output logic             busy_o,
  output logic [11:0]      result_o,
  output logic             done_o
);

  sar_phase_e phase;
  logic [3:0] nbits;
  logic       arm, step, last;

  sar_seq_fsm #(.ACQ_W(ACQ_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .res_sel_i (res_sel_i),
    .acq_len_i (acq_len_i),
    .phase_o   (phase),
    .nbits_o   (nbits),
    .arm_o     (arm),
    .step_o    (step),
    .last_o    (last)
  );

  sar_trial_reg u_trial (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm),
    .step_i   (step),
    .last_i   (last),
    .cmp_i    (cmp_i),
    .nbits_i  (nbits),
    .sw_o     (sw_o),
    .result_o (result_o),
    .done_o   (done_o)
  );

  assign phase_o = phase;
  assign busy_o  = (phase != PH_IDLE);

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk
  import sar_pkg::*;
#(
  parameter int unsigned ACQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [1:0]       res_sel_i,
  input logic [ACQ_W-1:0] acq_len_i,
  input logic [11:0]      sw_o,
  input logic [2:0]       phase_o,
  input logic             busy_o,
  input logic [11:0]      result_o,
  input logic             done_o
);

  logic [3:0]       nb_q;
  logic [ACQ_W-1:0] exp_acq_q;
  logic [ACQ_W:0]   acq_seen_q;
  logic [11:0]      low_mask;
  logic             accept;

  assign accept   = (phase_o == PH_IDLE) && start_i;
  assign low_mask = (12'd1 << (12 - 32'(nb_q))) - 12'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb_q      <= 4'd12;
      exp_acq_q <= ACQ_W'(1);
    end else if (accept) begin
      nb_q      <= res_width(res_sel_i);
      exp_acq_q <= (acq_len_i == '0) ? ACQ_W'(1) : acq_len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   acq_seen_q <= '0;
    else if (phase_o == PH_DISCH) acq_seen_q <= '0;
    else if (phase_o == PH_ACQ)   acq_seen_q <= acq_seen_q + 1'b1;
  end

  p_idle_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_IDLE) |-> (sw_o == '0 && !busy_o));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_o && phase_o == PH_DISCH));

  p_disch_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_DISCH) |=> (phase_o == PH_ACQ));

  p_quiet_sw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != PH_TRIAL) |-> (sw_o == '0));

  p_acq_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_HOLD) |-> (acq_seen_q == {1'b0, exp_acq_q}));

  p_hold_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_HOLD) |=> (phase_o == PH_TRIAL && sw_o == 12'h800));

  p_unused_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_TRIAL) |-> ((sw_o & low_mask) == '0));

  p_result_just_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((result_o & ~(12'hFFF >> (12 - 32'(nb_q)))) == '0));

  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (phase_o != PH_DISCH));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.ACQ_W(ACQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .res_sel_i (res_sel_i),
  .acq_len_i (acq_len_i),
  .sw_o      (sw_o),
  .phase_o   (phase_o),
  .busy_o    (busy_o),
  .result_o  (result_o),
  .done_o    (done_o)
);

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  res_sel_i;
  logic [7:0]  acq_len_i;
  logic        cmp_i;
  logic [11:0] sw_o;
  logic [2:0]  phase_o;
  logic        busy_o;
  logic [11:0] result_o;
  logic        done_o;
  logic [11:0] vin;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // Comparator model: 1 when the input code is at or above the trial level.
  assign cmp_i = (vin >= sw_o);

  sar_conv_seq #(.ACQ_W(8)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .res_sel_i (res_sel_i),
    .acq_len_i (acq_len_i),
    .cmp_i     (cmp_i),
    .sw_o      (sw_o),
    .phase_o   (phase_o),
    .busy_o    (busy_o),
    .result_o  (result_o),
    .done_o    (done_o)
  );

  // {res_sel[21:20], acq_len[19:12], vin[11:0]}
  localparam int NVEC = 10;
  localparam logic [21:0] VEC [0:NVEC-1] = '{
    {2'd2, 8'd1, 12'hA5C},
    {2'd2, 8'd3, 12'h000},
    {2'd2, 8'd2, 12'hFFF},
    {2'd0, 8'd1, 12'h7F3},
    {2'd0, 8'd5, 12'hFFF},
    {2'd1, 8'd4, 12'h801},
    {2'd1, 8'd1, 12'h3FF},
    {2'd3, 8'd2, 12'h123},
    {2'd0, 8'd0, 12'h0FF},
    {2'd2, 8'd7, 12'h7FF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] sel);
    return (sel == 2'd0) ? 8 : (sel == 2'd1) ? 10 : 12;
  endfunction

  // One conversion; disturb pulses start and new settings mid-run (R11, R12).
  task automatic run_conv(input logic [1:0] sel, input logic [7:0] acq,
                          input logic [11:0] v, input bit disturb);
    int n = nbits_of(sel);
    int a = (acq == 8'd0) ? 1 : int'(acq);
    int exp_cyc = a + n + 2;
    logic [11:0] exp_res = v >> (12 - n);
    logic [11:0] lowm = (12'd1 << (12 - n)) - 12'd1;
    logic [11:0] held;
    int cyc = 0;
    bit swbad = 0;
    @(negedge clk);
    res_sel_i = sel; acq_len_i = acq; vin = v; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after accept", busy_o, 1);
    chk("R3 discharge phase", phase_o, 1);
    while (busy_o && cyc < 5000) begin
      cyc++;
      if (phase_o != 3'd4 && sw_o != 12'd0) swbad = 1;
      if (phase_o == 3'd4 && (sw_o & lowm) != 12'd0) swbad = 1;
      if (disturb && (cyc == 2 || cyc == 3)) begin
        start_i = 1'b1; res_sel_i = 2'd2; acq_len_i = 8'd9;
      end else if (disturb && cyc == 4) begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    chk(disturb ? "R11 R12 busy length" : "R9 R4 busy length", cyc, exp_cyc);
    chk("R10 done at busy fall", done_o, 1);
    chk(disturb ? "R12 result" : "R8 result", result_o, exp_res);
    chk("R7 R3 switch use", swbad, 0);
    held = result_o;
    @(negedge clk);
    chk("R10 done one cycle", done_o, 0);
    chk("R10 result held", result_o, held);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; res_sel_i = 2'd2; acq_len_i = 8'd1; vin = 12'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 phase", phase_o, 0);
    chk("R1 sw", sw_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 result", result_o, 0);

    for (int i = 0; i < NVEC; i++)
      run_conv(VEC[i][21:20], VEC[i][19:12], VEC[i][11:0], 1'b0);

    // R5 R6: trial-by-trial switch values, 12-bit, A=1, vin=0xA5C
    @(negedge clk);
    res_sel_i = 2'd2; acq_len_i = 8'd1; vin = 12'hA5C; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R3 discharge", phase_o, 1);
    @(negedge clk);
    chk("R4 acquire", phase_o, 2);
    @(negedge clk);
    chk("R5 hold phase", phase_o, 3);
    chk("R5 hold sw", sw_o, 0);
    @(negedge clk);
    chk("R5 first trial", sw_o, 12'h800);
    @(negedge clk);
    chk("R6 keep on 1", sw_o, 12'hC00);
    @(negedge clk);
    chk("R6 drop on 0", sw_o, 12'hA00);
    while (busy_o) @(negedge clk);
    chk("R8 result A5C", result_o, 12'hA5C);

    // R11 R12: start and new settings while busy
    run_conv(2'd0, 8'd2, 12'h5A7, 1'b1);

    // R1: reset in the middle of a conversion
    @(negedge clk);
    res_sel_i = 2'd1; acq_len_i = 8'd4; vin = 12'h333; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset busy", busy_o, 0);
    chk("R1 mid reset phase", phase_o, 0);
    chk("R1 mid reset sw", sw_o, 0);
    chk("R1 mid reset result", result_o, 0);
    rst_n = 1'b1;
    run_conv(2'd1, 8'd2, 12'h9C4, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule